// File: doc/BRIEF.md
# Link Resynchronization Sequencer

This block drives a resynchronization sequence on three serializer lanes at once. A sequence can start in two ways. A timing broadcast strobe that carries the configured resync command code starts it, but only while command-triggered resync is enabled. A software trigger starts it whatever the enable is set to. Once a sequence starts, every lane is switched to idle words for a programmable number of crossings (one crossing per clock). The lanes then carry a fixed test pattern for 16 crossings and go back to normal data. The receivers use this to regain bit alignment.

The block produces only a two-bit select for each lane. The datapath downstream uses it to choose normal data, the idle word or the pattern word. An 8-bit counter records how many sequences have been accepted. The counter can be cleared on its own without affecting a sequence that is running. The block has no streaming data interface. All of its pins are plain control and status signals, sampled on the rising clock edge.

Top module: `link_resync_seq`

## Requirements
- R1: While reset (rst_n low) is asserted and after it is released, every lane select reads normal (code 0) and the trigger count reads 0.
- R2: A cycle with bcast_stb high, bcast_cmd equal to the parameter RESYNC_CMD (default 8'h5A) and resync_en high starts a sequence when the block is idle. From the next cycle, all lanes read idle (code 1) for exactly idle_len cycles, where idle_len is the value sampled in the start cycle.
- R3: After the idle phase, all lanes read pattern (code 2) for exactly 16 cycles and then read normal (code 0).
- R4: A broadcast strobe with a different command code, a matching code while resync_en is low, or a matching code with no strobe starts no sequence and does not change the count.
- R5: sw_trig high for one cycle starts the same sequence when resync_en is low.
- R6: An idle_len of zero sampled at the start moves the lanes straight to pattern in the next cycle.
- R7: A trigger of either kind that arrives while a sequence is running, including in its last pattern cycle, is ignored. It does not restart or extend the sequence and is not counted.
- R8: Each accepted start raises trig_count by one in the next cycle. The count holds at 255 and does not wrap.
- R9: cnt_clr high sets trig_count to 0 in the next cycle, even if a start is accepted in the same cycle. Clearing does not alter the lane selects.
- R10: The three lane selects in lane_sel (lane n at bits 2n+1:2n) always carry the same code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one crossing per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| bcast_stb | input | 1 | Broadcast command valid strobe |
| bcast_cmd | input | 8 | Broadcast command code |
| resync_en | input | 1 | Enables starting on the broadcast command |
| sw_trig | input | 1 | Software start request |
| idle_len | input | 12 | Idle phase length in crossings |
| cnt_clr | input | 1 | Clears the trigger count |
| lane_sel | output | 6 | Per-lane select: 0 normal, 1 idle, 2 pattern |
| trig_count | output | 8 | Saturating count of accepted starts |

## Verification
A phase register left in the wrong state shows up on the lane selects in the very next cycle. The visible symptoms are an idle phase one crossing too long or too short, a pattern phase that is not 16 cycles, or a sequence that restarts when a trigger arrives late. The phase-duration counter can only be seen through when the selects change, so the bench counts every cycle of each phase over several idle lengths, including zero. A wrong count path shows on trig_count one cycle after the trigger that was accepted, ignored or cleared, and again at the 255 ceiling.

// File: rtl/resync_pkg.sv
package resync_pkg;
  typedef enum logic [1:0] {
    PH_NORMAL  = 2'd0,
    PH_IDLE    = 2'd1,
    PH_PATTERN = 2'd2
  } phase_e;
endpackage

// File: rtl/resync_trigger.sv
module resync_trigger #(
  parameter int          CMD_W      = 8,
  parameter logic [7:0]  RESYNC_CMD = 8'h5A
) (
  input  logic             bcast_stb,
  input  logic [CMD_W-1:0] bcast_cmd,
  input  logic             resync_en,
  input  logic             sw_trig,
  output logic             start_req
);
  logic cmd_hit;

  always_comb begin
    cmd_hit   = bcast_stb && (bcast_cmd == CMD_W'(RESYNC_CMD));
    start_req = sw_trig || (resync_en && cmd_hit);
  end
endmodule

// File: rtl/resync_fsm.sv
module resync_fsm
  import resync_pkg::*;
#(
  parameter int IDLE_W  = 12,
  parameter int PAT_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [IDLE_W-1:0] idle_len,
  output phase_e            phase,
  output logic              accept
);
  localparam int PAT_W = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;
  localparam int DUR_W = (IDLE_W > PAT_W) ? IDLE_W : PAT_W;

  logic [DUR_W-1:0] dur;

  assign accept = (phase == PH_NORMAL) && start_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_NORMAL;
      dur   <= '0;
    end else begin
      unique case (phase)
        PH_NORMAL: begin
          if (start_req) begin
            if (idle_len == '0) begin
              phase <= PH_PATTERN;
              dur   <= DUR_W'(PAT_LEN - 1);
            end else begin
              phase <= PH_IDLE;
              dur   <= DUR_W'(idle_len - 1'b1);
            end
          end
        end
        PH_IDLE: begin
          if (dur == '0) begin
            phase <= PH_PATTERN;
            dur   <= DUR_W'(PAT_LEN - 1);
          end else begin
            dur <= dur - 1'b1;
          end
        end
        PH_PATTERN: begin
          if (dur == '0) phase <= PH_NORMAL;
          else           dur   <= dur - 1'b1;
        end
        default: phase <= PH_NORMAL;
      endcase
    end
  end

  p_start_only_on_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_NORMAL && !start_req) |=> (phase == PH_NORMAL));

  p_idle_leads_to_pattern_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |=> (phase != PH_NORMAL));

  p_zero_idle_skips_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_NORMAL && start_req && idle_len == '0) |=> (phase == PH_PATTERN));

  p_pattern_never_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PATTERN) |=> (phase != PH_IDLE));
endmodule

// File: rtl/resync_counter.sv
module resync_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)                       count <= '0;
    else if (clr)                     count <= '0;
    else if (inc && count != CNT_MAX) count <= count + 1'b1;
  end

  p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !clr) |=> (count == CNT_MAX));

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  p_step_of_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && count != CNT_MAX) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/link_resync_seq.sv
module link_resync_seq
  import resync_pkg::*;
#(
  parameter int         CMD_W      = 8,
  parameter logic [7:0] RESYNC_CMD = 8'h5A,
  parameter int         IDLE_W     = 12,
  parameter int         PAT_LEN    = 16,
  parameter int         CNT_W      = 8,
  parameter int         N_LANES    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bcast_stb,
  input  logic [CMD_W-1:0]     bcast_cmd,
  input  logic                 resync_en,
  input  logic                 sw_trig,
  input  logic [IDLE_W-1:0]    idle_len,
  input  logic                 cnt_clr,
  output logic [2*N_LANES-1:0] lane_sel,
  output logic [CNT_W-1:0]     trig_count
);
  logic   start_req;
  logic   accept;
  phase_e phase;

  resync_trigger #(.CMD_W(CMD_W), .RESYNC_CMD(RESYNC_CMD)) u_trigger (
    .bcast_stb (bcast_stb),
    .bcast_cmd (bcast_cmd),
    .resync_en (resync_en),
    .sw_trig   (sw_trig),
    .start_req (start_req)
  );

  resync_fsm #(.IDLE_W(IDLE_W), .PAT_LEN(PAT_LEN)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .idle_len  (idle_len),
    .phase     (phase),
    .accept    (accept)
  );

  resync_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (accept),
    .clr   (cnt_clr),
    .count (trig_count)
  );

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign lane_sel[2*g +: 2] = phase;
  end

  p_busy_no_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_NORMAL && !cnt_clr) |=> $stable(trig_count));

  for (genvar g = 1; g < N_LANES; g++) begin : g_agree
    p_lanes_agree_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lane_sel[2*g +: 2] == lane_sel[1:0]);
  end
endmodule

// File: tb/link_resync_seq_bench.sv
module link_resync_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] SEL_NORM = 6'b000000;
  localparam logic [5:0] SEL_IDLE = 6'b010101;
  localparam logic [5:0] SEL_PAT  = 6'b101010;

  typedef struct packed {
    logic        stb;
    logic [7:0]  cmd;
    logic        en;
    logic        sw;
    logic [11:0] idle;
    logic        start;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 8'h5A, 1'b1, 1'b0, 12'd3, 1'b1},
    '{1'b1, 8'h5B, 1'b1, 1'b0, 12'd3, 1'b0},
    '{1'b1, 8'h5A, 1'b0, 1'b0, 12'd3, 1'b0},
    '{1'b0, 8'h5A, 1'b1, 1'b1, 12'd5, 1'b1},
    '{1'b0, 8'h00, 1'b0, 1'b1, 12'd1, 1'b1},
    '{1'b1, 8'h5A, 1'b1, 1'b0, 12'd0, 1'b1},
    '{1'b0, 8'h5A, 1'b1, 1'b0, 12'd2, 1'b0},
    '{1'b1, 8'h5A, 1'b1, 1'b1, 12'd7, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bcast_stb;
  logic [7:0]  bcast_cmd;
  logic        resync_en;
  logic        sw_trig;
  logic [11:0] idle_len;
  logic        cnt_clr;
  logic [5:0]  lane_sel;
  logic [7:0]  trig_count;

  int errors = 0;
  int checks = 0;
  int exp_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_resync_seq u_link_resync_seq (
    .clk(clk), .rst_n(rst_n), .bcast_stb(bcast_stb), .bcast_cmd(bcast_cmd),
    .resync_en(resync_en), .sw_trig(sw_trig), .idle_len(idle_len),
    .cnt_clr(cnt_clr), .lane_sel(lane_sel), .trig_count(trig_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic quiet();
    bcast_stb = 1'b0; sw_trig = 1'b0; cnt_clr = 1'b0;
  endtask

  // Walks the timeline after the start edge has been sampled.
  task automatic run_seq(input string req, input int len);
    for (int j = 0; j < len; j++) begin
      chk({req, " idle phase R2"}, lane_sel, SEL_IDLE);
      tick();
    end
    for (int j = 0; j < 16; j++) begin
      chk({req, " pattern phase R3"}, lane_sel, SEL_PAT);
      tick();
    end
    chk({req, " back to normal R3 R10"}, lane_sel, SEL_NORM);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; quiet(); bcast_cmd = 8'h00; resync_en = 1'b0; idle_len = '0;
    tick();
    chk("R1 sel in reset", lane_sel, SEL_NORM);
    chk("R1 count in reset", trig_count, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 sel after reset", lane_sel, SEL_NORM);
    chk("R1 count after reset", trig_count, 0);

    // Table walk: R2 R4 R5 R6
    foreach (VECS[i]) begin
      bcast_stb = VECS[i].stb; bcast_cmd = VECS[i].cmd;
      resync_en = VECS[i].en;  sw_trig   = VECS[i].sw;
      idle_len  = VECS[i].idle;
      tick();
      quiet();
      idle_len = 12'd9;  // changing after start must not matter (R2)
      if (VECS[i].start) begin
        if (exp_cnt < 255) exp_cnt++;
        chk("R8 count after start", trig_count, exp_cnt);
        run_seq("vector", int'(VECS[i].idle));
      end else begin
        chk("R4 no start sel", lane_sel, SEL_NORM);
        chk("R4 no start count", trig_count, exp_cnt);
      end
      tick();
    end

    // R7: trigger held through the whole sequence, dropped before last edge
    resync_en = 1'b1; idle_len = 12'd4; sw_trig = 1'b1;
    tick();
    exp_cnt++;
    for (int j = 0; j < 4; j++) begin
      bcast_stb = 1'b1; bcast_cmd = 8'h5A;
      chk("R7 idle unaffected", lane_sel, SEL_IDLE);
      tick();
    end
    for (int j = 0; j < 16; j++) begin
      chk("R7 pattern unaffected", lane_sel, SEL_PAT);
      chk("R7 not counted", trig_count, exp_cnt);
      if (j == 15) quiet();
      tick();
    end
    chk("R7 ends normal", lane_sel, SEL_NORM);
    chk("R7 count once", trig_count, exp_cnt);

    // R9: clear alone, then clear together with a start
    cnt_clr = 1'b1;
    tick();
    quiet();
    chk("R9 cleared", trig_count, 0);
    chk("R9 sel unaffected", lane_sel, SEL_NORM);
    idle_len = 12'd0; sw_trig = 1'b1; cnt_clr = 1'b1;
    tick();
    quiet();
    exp_cnt = 0;
    chk("R9 clear beats increment", trig_count, 0);
    chk("R6 R9 straight to pattern", lane_sel, SEL_PAT);
    for (int j = 0; j < 3; j++) tick();
    cnt_clr = 1'b1;
    tick();
    cnt_clr = 1'b0;
    chk("R9 clear mid-sequence keeps pattern", lane_sel, SEL_PAT);
    for (int j = 0; j < 12; j++) tick();
    chk("R3 normal after 16 pattern", lane_sel, SEL_NORM);

    // R8: saturation at 255
    idle_len = 12'd0;
    for (int k = 0; k < 258; k++) begin
      sw_trig = 1'b1;
      tick();
      sw_trig = 1'b0;
      if (exp_cnt < 255) exp_cnt++;
      for (int j = 0; j < 16; j++) tick();
    end
    chk("R8 saturated", trig_count, 255);
    chk("R8 saturated expected", trig_count, exp_cnt);

    // R1: reset in the middle of a sequence
    idle_len = 12'd6; sw_trig = 1'b1;
    tick();
    sw_trig = 1'b0;
    tick();
    chk("R2 idle before reset", lane_sel, SEL_IDLE);
    rst_n = 1'b0;
    tick();
    chk("R1 mid-sequence reset sel", lane_sel, SEL_NORM);
    chk("R1 mid-sequence reset count", trig_count, 0);
    rst_n = 1'b1;
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule